// File: doc/BRIEF.md
# Vector Instruction Issue and Sequencing Unit

This block sits at the issue stage of a small signal-processing core. It takes one 16-bit instruction word per cycle and sorts it into one of four kinds: a scalar instruction, a wait instruction, a vector instruction or an accelerator-control instruction. Scalar and accelerator words are passed on as registered one-cycle issue strobes, together with their payload fields.

A vector word starts a background engine. The engine loads the operation code and the port select and then walks an element index, one element per cycle, for as many elements as the size field gives. It raises a done pulse on the last element. While the engine runs, scalar and accelerator words keep issuing at full rate. A wait word, or a second vector word, holds the ready output low until the engine is idle again. This lets control code run in the shadow of a long vector operation.

Top module: `vec_issue_seq`

## Requirements
- R1: Out of a synchronous active-high reset, `instr_ready` is 1 and `sc_valid`, `acc_valid`, `vec_busy`, `vec_elem` and `vec_done` are all 0.
- R2: An accepted word with bit 15 = 0 that is not a wait word gives `sc_valid` = 1 in the following cycle only, with `sc_word` equal to bits 14:0 of the word.
- R3: An accepted word with bits 15:14 = 11 gives `acc_valid` = 1 in the following cycle only, with `acc_id` = bits 13:10 and `acc_cmd` = bits 9:0.
- R4: An accepted word with bits 15:14 = 10 is a vector word. It has operation bits 13:10, port bits 9:7 and size bits 6:0. In the next cycle `vec_busy` rises and `vec_op`/`vec_port` hold the word's fields.
- R5: A vector operation of size N gives `vec_elem` = 1 on N consecutive cycles with `vec_idx` = 0, 1, ..., N-1. A size field of 0 means N = 128.
- R6: `vec_done` is 1 on exactly the cycle of the final element, and on no other cycle.
- R7: `vec_busy` falls in the cycle after the final element.
- R8: Scalar and accelerator words are accepted (`instr_ready` = 1) while the vector engine is busy.
- R9: A vector word presented while the engine is busy sees `instr_ready` = 0 until the engine is idle, and is then accepted. If it is presented in the first busy cycle of a size-N operation, it stalls for exactly N cycles.
- R10: A wait word (bit 15 = 0, bits 14:10 = 11111) stalls like R9 while the engine is busy. Once accepted, it issues nothing on the scalar or accelerator outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present |
| instr | input | 16 | Instruction word |
| instr_ready | output | 1 | Word is accepted in this cycle when valid |
| sc_valid | output | 1 | Scalar issue strobe |
| sc_word | output | 15 | Scalar instruction payload |
| acc_valid | output | 1 | Accelerator issue strobe |
| acc_id | output | 4 | Target accelerator |
| acc_cmd | output | 10 | Accelerator command |
| vec_busy | output | 1 | Vector engine running |
| vec_elem | output | 1 | Per-element operation strobe |
| vec_op | output | 4 | Current vector operation |
| vec_port | output | 3 | Current port select |
| vec_idx | output | 7 | Current element index |
| vec_done | output | 1 | Final element strobe |

## Verification
The hardest cases to reach are the stall windows. In these, a wait or vector word is held at the input for the whole remaining run of a vector operation. The stall count must equal the element count, with no slip of a single cycle at the busy-to-idle edge. The bench reaches them by presenting the stalling word in the first busy cycle of a known-size operation and counting ready-low cycles. It also runs the size-0 (128 element) case and a size-1 case, where the done pulse coincides with the first element.

// File: rtl/vis_pkg.sv
package vis_pkg;
  typedef enum logic [1:0] {
    CLS_SCALAR = 2'd0,
    CLS_WAIT   = 2'd1,
    CLS_VECTOR = 2'd2,
    CLS_ACCEL  = 2'd3
  } instr_cls_t;
endpackage

// File: rtl/vis_decode.sv
module vis_decode
  import vis_pkg::*;
#(
  parameter int VOP_W   = 4,
  parameter int VPORT_W = 3,
  parameter int VSIZE_W = 7,
  parameter int AID_W   = 4,
  parameter int ACMD_W  = 10,
  parameter int WAIT_W  = 5
) (
  input  logic [2+VOP_W+VPORT_W+VSIZE_W-1:0] word,
  output instr_cls_t                         cls,
  output logic [VOP_W-1:0]                   vop,
  output logic [VPORT_W-1:0]                 vport,
  output logic [VSIZE_W-1:0]                 vsize,
  output logic [AID_W-1:0]                   aid,
  output logic [ACMD_W-1:0]                  acmd
);
  localparam int IW = 2 + VOP_W + VPORT_W + VSIZE_W;

  always_comb begin
    if (!word[IW-1]) begin
      if (word[IW-2 -: WAIT_W] == {WAIT_W{1'b1}}) cls = CLS_WAIT;
      else                                        cls = CLS_SCALAR;
    end else if (!word[IW-2]) begin
      cls = CLS_VECTOR;
    end else begin
      cls = CLS_ACCEL;
    end
  end

  assign vop   = word[VPORT_W+VSIZE_W +: VOP_W];
  assign vport = word[VSIZE_W +: VPORT_W];
  assign vsize = word[0 +: VSIZE_W];
  assign aid   = word[ACMD_W +: AID_W];
  assign acmd  = word[0 +: ACMD_W];
endmodule

// File: rtl/vis_vec_engine.sv
module vis_vec_engine #(
  parameter int VOP_W   = 4,
  parameter int VPORT_W = 3,
  parameter int VSIZE_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [VOP_W-1:0]   op_in,
  input  logic [VPORT_W-1:0] port_in,
  input  logic [VSIZE_W-1:0] size_in,
  output logic               busy,
  output logic               last,
  output logic [VSIZE_W-1:0] idx,
  output logic [VOP_W-1:0]   op_q,
  output logic [VPORT_W-1:0] port_q
);
  // size - 1 wraps so that a zero size spans the full index range
  logic [VSIZE_W-1:0] last_idx_q;
  logic [VSIZE_W-1:0] idx_nxt;

  assign idx_nxt = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      last       <= 1'b0;
      idx        <= '0;
      last_idx_q <= '0;
      op_q       <= '0;
      port_q     <= '0;
    end else if (start) begin
      busy       <= 1'b1;
      idx        <= '0;
      last_idx_q <= size_in - 1'b1;
      last       <= (size_in == VSIZE_W'(1));
      op_q       <= op_in;
      port_q     <= port_in;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
        last <= 1'b0;
      end else begin
        idx  <= idx_nxt;
        last <= (idx_nxt == last_idx_q);
      end
    end
  end
endmodule

// File: rtl/vis_issue_regs.sv
module vis_issue_regs #(
  parameter int SC_W   = 15,
  parameter int AID_W  = 4,
  parameter int ACMD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sc_fire,
  input  logic [SC_W-1:0]   sc_in,
  input  logic              acc_fire,
  input  logic [AID_W-1:0]  aid_in,
  input  logic [ACMD_W-1:0] acmd_in,
  output logic              sc_valid,
  output logic [SC_W-1:0]   sc_word,
  output logic              acc_valid,
  output logic [AID_W-1:0]  acc_id,
  output logic [ACMD_W-1:0] acc_cmd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sc_valid  <= 1'b0;
      acc_valid <= 1'b0;
      sc_word   <= '0;
      acc_id    <= '0;
      acc_cmd   <= '0;
    end else begin
      sc_valid  <= sc_fire;
      acc_valid <= acc_fire;
      if (sc_fire) sc_word <= sc_in;
      if (acc_fire) begin
        acc_id  <= aid_in;
        acc_cmd <= acmd_in;
      end
    end
  end
endmodule

// File: rtl/vec_issue_seq.sv
module vec_issue_seq
  import vis_pkg::*;
#(
  parameter int VOP_W   = 4,
  parameter int VPORT_W = 3,
  parameter int VSIZE_W = 7,
  parameter int AID_W   = 4,
  parameter int ACMD_W  = 10,
  parameter int WAIT_W  = 5,
  localparam int IW     = 2 + VOP_W + VPORT_W + VSIZE_W,
  localparam int SC_W   = IW - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  input  logic [IW-1:0]      instr,
  output logic               instr_ready,
  output logic               sc_valid,
  output logic [SC_W-1:0]    sc_word,
  output logic               acc_valid,
  output logic [AID_W-1:0]   acc_id,
  output logic [ACMD_W-1:0]  acc_cmd,
  output logic               vec_busy,
  output logic               vec_elem,
  output logic [VOP_W-1:0]   vec_op,
  output logic [VPORT_W-1:0] vec_port,
  output logic [VSIZE_W-1:0] vec_idx,
  output logic               vec_done
);
  instr_cls_t         cls;
  logic [VOP_W-1:0]   d_vop;
  logic [VPORT_W-1:0] d_vport;
  logic [VSIZE_W-1:0] d_vsize;
  logic [AID_W-1:0]   d_aid;
  logic [ACMD_W-1:0]  d_acmd;
  logic               accept;
  logic               needs_idle;

  vis_decode #(
    .VOP_W(VOP_W), .VPORT_W(VPORT_W), .VSIZE_W(VSIZE_W),
    .AID_W(AID_W), .ACMD_W(ACMD_W), .WAIT_W(WAIT_W)
  ) u_dec (
    .word(instr), .cls(cls), .vop(d_vop), .vport(d_vport),
    .vsize(d_vsize), .aid(d_aid), .acmd(d_acmd)
  );

  assign needs_idle  = (cls == CLS_VECTOR) || (cls == CLS_WAIT);
  assign instr_ready = !(needs_idle && vec_busy);
  assign accept      = instr_valid && instr_ready;

  vis_vec_engine #(
    .VOP_W(VOP_W), .VPORT_W(VPORT_W), .VSIZE_W(VSIZE_W)
  ) u_eng (
    .clk(clk), .rst(rst),
    .start(accept && (cls == CLS_VECTOR)),
    .op_in(d_vop), .port_in(d_vport), .size_in(d_vsize),
    .busy(vec_busy), .last(vec_done), .idx(vec_idx),
    .op_q(vec_op), .port_q(vec_port)
  );

  assign vec_elem = vec_busy;

  vis_issue_regs #(
    .SC_W(SC_W), .AID_W(AID_W), .ACMD_W(ACMD_W)
  ) u_iss (
    .clk(clk), .rst(rst),
    .sc_fire(accept && (cls == CLS_SCALAR)),
    .sc_in(instr[SC_W-1:0]),
    .acc_fire(accept && (cls == CLS_ACCEL)),
    .aid_in(d_aid), .acmd_in(d_acmd),
    .sc_valid(sc_valid), .sc_word(sc_word),
    .acc_valid(acc_valid), .acc_id(acc_id), .acc_cmd(acc_cmd)
  );
endmodule

// File: rtl/vec_issue_seq_chk.sv
module vec_issue_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        instr_valid,
  input logic [15:0] instr,
  input logic        instr_ready,
  input logic        sc_valid,
  input logic [14:0] sc_word,
  input logic        acc_valid,
  input logic        vec_busy,
  input logic        vec_elem,
  input logic [6:0]  vec_idx,
  input logic        vec_done
);
  logic is_vec, is_acc, is_wait, is_sc;
  assign is_vec  = instr[15:14] == 2'b10;
  assign is_acc  = instr[15:14] == 2'b11;
  assign is_wait = !instr[15] && (instr[14:10] == 5'b11111);
  assign is_sc   = !instr[15] && !is_wait;

  // R2
  scalar_issue_chk: assert property (@(posedge clk) disable iff (rst)
    instr_valid && instr_ready && is_sc |=> sc_valid && sc_word == $past(instr[14:0]));
  // R3
  accel_issue_chk: assert property (@(posedge clk) disable iff (rst)
    instr_valid && instr_ready && is_acc |=> acc_valid);
  // R4
  vec_start_chk: assert property (@(posedge clk) disable iff (rst)
    instr_valid && instr_ready && is_vec |=> vec_busy && vec_idx == 7'd0);
  // R5
  elem_step_chk: assert property (@(posedge clk) disable iff (rst)
    vec_busy && !vec_done |=> vec_elem && vec_idx == $past(vec_idx) + 7'd1);
  // R6
  done_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    vec_done |-> vec_busy && vec_elem);
  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    vec_done |=> !vec_busy);
  // R8
  accel_not_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    instr_valid && (is_acc || is_sc) |-> instr_ready);
  // R9
  vec_stall_chk: assert property (@(posedge clk) disable iff (rst)
    instr_valid && is_vec && vec_busy |-> !instr_ready);
  // R10
  wait_silent_chk: assert property (@(posedge clk) disable iff (rst)
    instr_valid && instr_ready && is_wait |=> !sc_valid && !acc_valid);
endmodule

bind vec_issue_seq vec_issue_seq_chk u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
  .instr_ready(instr_ready), .sc_valid(sc_valid), .sc_word(sc_word),
  .acc_valid(acc_valid), .vec_busy(vec_busy), .vec_elem(vec_elem),
  .vec_idx(vec_idx), .vec_done(vec_done)
);

// File: tb/vec_issue_seq_test.sv
module vec_issue_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic        instr_ready, sc_valid, acc_valid, vec_busy, vec_elem, vec_done;
  logic [14:0] sc_word;
  logic [3:0]  acc_id, vec_op;
  logic [9:0]  acc_cmd;
  logic [2:0]  vec_port;
  logic [6:0]  vec_idx;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vec_issue_seq uut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .instr_ready(instr_ready), .sc_valid(sc_valid), .sc_word(sc_word),
    .acc_valid(acc_valid), .acc_id(acc_id), .acc_cmd(acc_cmd),
    .vec_busy(vec_busy), .vec_elem(vec_elem), .vec_op(vec_op),
    .vec_port(vec_port), .vec_idx(vec_idx), .vec_done(vec_done)
  );

  // entry: {word[15:0], kind[1:0], payload[14:0]}; kind 0 scalar, 1 accel, 2 wait
  localparam int NVEC = 8;
  localparam logic [32:0] TABLE [NVEC] = '{
    {16'h0000, 2'd0, 15'h0000},
    {16'h1234, 2'd0, 15'h1234},
    {16'h7BFF, 2'd0, 15'h7BFF},
    {16'h7C00, 2'd2, 15'h0000},
    {16'hC3FF, 2'd1, 15'h03FF},
    {16'hF001, 2'd1, 15'h3001},
    {16'hFFFF, 2'd1, 15'h3FFF},
    {16'h7FFF, 2'd2, 15'h0000}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // presents w, waits for acceptance; returns after the edge with outputs settled
  task automatic send(input logic [15:0] w, output int stalls);
    @(negedge clk);
    instr_valid = 1'b1;
    instr = w;
    #1;
    stalls = 0;
    while (!instr_ready) begin
      @(negedge clk);
      #1;
      stalls++;
    end
    @(posedge clk);
    #1;
    instr_valid = 1'b0;
  endtask

  // walks a running operation from the current cycle, which must be idx 0
  task automatic walk(input int n);
    int dones = 0;
    for (int k = 0; k < n; k++) begin
      check(vec_elem && vec_idx == 7'(k), "R5", int'(vec_idx), k);
      if (vec_done) dones++;
      if (k == n - 1) check(vec_done == 1'b1, "R6", int'(vec_done), 1);
      @(posedge clk);
      #1;
    end
    check(dones == 1, "R6", dones, 1);
    check(!vec_busy && !vec_elem, "R7", int'(vec_busy), 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int st;
    repeat (3) @(posedge clk);
    #1;
    // R1
    check(instr_ready && !sc_valid && !acc_valid && !vec_busy && !vec_elem && !vec_done,
          "R1", int'({sc_valid, acc_valid, vec_busy, vec_done}), 0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      send(TABLE[i][32:17], st);
      case (TABLE[i][16:15])
        2'd0: check(sc_valid && !acc_valid && sc_word == TABLE[i][14:0], "R2",
                    int'(sc_word), int'(TABLE[i][14:0]));
        2'd1: check(acc_valid && !sc_valid && {acc_id, acc_cmd} == TABLE[i][13:0], "R3",
                    int'({acc_id, acc_cmd}), int'(TABLE[i][13:0]));
        default: check(!sc_valid && !acc_valid, "R10", int'({sc_valid, acc_valid}), 0);
      endcase
      @(posedge clk);
      #1;
      check(!sc_valid && !acc_valid, "R2", int'({sc_valid, acc_valid}), 0);
    end

    // R4/R5/R6/R7: op 9, port 5, size 5
    send({2'b10, 4'd9, 3'd5, 7'd5}, st);
    check(vec_busy && vec_op == 4'd9 && vec_port == 3'd5, "R4", int'(vec_op), 9);
    walk(5);

    // size 1: done on first element
    send({2'b10, 4'd2, 3'd1, 7'd1}, st);
    check(vec_done && vec_idx == 7'd0, "R6", int'(vec_done), 1);
    walk(1);

    // size 0 means 128 elements
    send({2'b10, 4'd3, 3'd0, 7'd0}, st);
    walk(128);

    // R8: scalar and accelerator issue while busy
    send({2'b10, 4'd1, 3'd2, 7'd10}, st);
    send(16'h0ABC, st);
    check(st == 0 && sc_valid && sc_word == 15'h0ABC && vec_busy, "R8", st, 0);
    send(16'hD155, st);
    check(st == 0 && acc_valid && acc_id == 4'h4 && acc_cmd == 10'h155, "R8",
          int'(acc_cmd), 'h155);
    repeat (12) @(posedge clk);
    #1;

    // R9: second vector stalls for the whole size-6 run
    send({2'b10, 4'd4, 3'd3, 7'd6}, st);
    send({2'b10, 4'd7, 3'd6, 7'd3}, st);
    check(st == 6, "R9", st, 6);
    check(vec_busy && vec_op == 4'd7 && vec_port == 3'd6 && vec_idx == 7'd0, "R9",
          int'(vec_op), 7);
    walk(3);

    // R10: wait stalls for the whole size-4 run and issues nothing
    send({2'b10, 4'd5, 3'd4, 7'd4}, st);
    send(16'h7FFF, st);
    check(st == 4, "R10", st, 4);
    check(!vec_busy && !sc_valid && !acc_valid, "R10", int'({vec_busy, sc_valid, acc_valid}), 0);

    // wait on an idle engine is accepted at once
    send(16'h7C55, st);
    check(st == 0 && !sc_valid, "R10", st, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule